// File: doc/BRIEF.md
# Pipelined Vector Rotator with Exact Quarter-Turn Pre-stage

This block turns a complex sample (signed `inX`, `inY`) clockwise by the angle 2π·θ/N. Here θ is the unsigned integer on `inAngle` and N = 2^ANGLE_W. It sits next to an FFT angle counter: a sample, its angle index and a valid strobe enter together, and the rotated sample leaves a fixed number of cycles later. A new sample may enter on every clock.

The rotation is split into two parts. The top two bits of θ and the bit below them pick a whole quarter turn. That quarter turn is applied exactly, by swapping and negating the components. What is left is a residual angle in the range [−45°, 45°]. The residual is turned into a fixed-point radian value. A chain of registered shift-and-add stages then removes it. Stage i turns the vector by ±atan(2^-i), for i = 1..STAGES, and it always turns; there is no stage for i = 0.

Each stage takes its direction from the sign of the residual that remains. The constant gain of the implemented stages is taken out by one fixed-point multiply at the end, with rounding and saturation.

Top module: `cordic_rotator`

## Requirements
- R1: For each accepted sample, with φ = 2π·θ/N, `outX` equals round(x·cos φ + y·sin φ) and `outY` equals round(−x·sin φ + y·cos φ), each saturated to the output range, within ±4 LSB at the default parameters.
- R2: The coarse step uses bits [ANGLE_W−1:ANGLE_W−2] of θ plus bit ANGLE_W−3, added modulo 4, to choose a clockwise turn of 0°, 90°, 180° or 270°. The turn is made only by swapping and negating, so it keeps |x|+|y| unchanged. Angles at exact multiples of N/4 meet R1.
- R3: After the coarse step the residual angle lies in [−45°, 45°]. Angles just below and just above the odd multiples of N/8 meet R1.
- R4: `outValid` is high on the cycle that begins STAGES+1 rising edges after the edge that captured the sample with `inValid` high. Every accepted sample produces exactly one output.
- R5: Samples offered on consecutive cycles are all accepted with no stall. They come out on consecutive cycles in the same order.
- R6: While `outValid` is low, `outX` and `outY` keep the last result. Values on `inX`, `inY` and `inAngle` while `inValid` is low have no effect on any output.
- R7: Results beyond the output range are clamped to −2^(DATA_W−1) or 2^(DATA_W−1)−1.
- R8: The stage gain is compensated, so the magnitude is preserved. An input of (20000, 0) at θ = 0 gives (20000, 0) within ±4 LSB.
- R9: While `rstN` is low and after it is released, `outValid` is 0 and `outX` and `outY` are 0 until the first result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A sample is offered this cycle |
| inAngle | input | ANGLE_W | Angle index θ; clockwise turn of 2π·θ/N |
| inX | input | DATA_W | Real part of the input, two's complement |
| inY | input | DATA_W | Imaginary part of the input, two's complement |
| outValid | output | 1 | A rotated result is on the outputs |
| outX | output | DATA_W | Real part of the result |
| outY | output | DATA_W | Imaginary part of the result |

## Verification
The hardest case to reach from the ports is a residual angle sitting right at ±45°. That is where the quarter-turn choice flips and the shift-and-add chain must use almost all of its reach. The stimulus hits it with index values one below and exactly at the odd eighths of a turn. Saturation is reached with full-scale inputs turned 45° toward a diagonal, and with the most negative value turned half a turn. Idle gaps filled with garbage inputs are placed between bursts, so the hold behaviour and the latency are checked with both dense and sparse traffic.

// File: rtl/cordic_rot_pkg.sv
package cordic_rot_pkg;

  // Clockwise quarter-turn chosen by the coarse stage
  typedef enum logic [1:0] {
    QUAD_NONE  = 2'd0,
    QUAD_CW90  = 2'd1,
    QUAD_CW180 = 2'd2,
    QUAD_CW270 = 2'd3
  } quadSel_e;

  // Strobes from control to datapath for the coarse stage
  typedef struct packed {
    quadSel_e quad;
    logic     take;
  } coarseStrobe_t;

  function automatic real powTwo(input int e);
    real r;
    r = 1.0;
    for (int i = 0; i < e; i++) r = r * 2.0;
    return r;
  endfunction

  // round(atan(2^-idx) * 2^frac), by power series
  function automatic int atanFixed(input int idx, input int frac);
    real t, t2, term, sum;
    t = 1.0 / powTwo(idx);
    t2 = t * t;
    term = t;
    sum = 0.0;
    for (int n = 0; n < 40; n++) begin
      if (n % 2 == 0) sum = sum + term / (2.0 * n + 1.0);
      else            sum = sum - term / (2.0 * n + 1.0);
      term = term * t2;
    end
    return $rtoi(sum * powTwo(frac) + 0.5);
  endfunction

  // round(2^bits / prod sqrt(1 + 4^-i)), i = 1..stages
  function automatic int gainFixed(input int stages, input int bits);
    real k2, p, g;
    k2 = 1.0;
    p = 1.0;
    for (int i = 1; i <= stages; i++) begin
      p = p / 4.0;
      k2 = k2 * (1.0 + p);
    end
    g = k2;
    for (int n = 0; n < 30; n++) g = 0.5 * (g + k2 / g);
    return $rtoi(powTwo(bits) / g + 0.5);
  endfunction

  // round(2*pi / 2^angleW * 2^frac): radians per index step
  function automatic int stepFixed(input int angleW, input int frac);
    return $rtoi(6.283185307179586 * powTwo(frac) / powTwo(angleW) + 0.5);
  endfunction

  function automatic int quarterPiFixed(input int frac);
    return $rtoi(0.7853981633974483 * powTwo(frac) + 0.5);
  endfunction

endpackage

// File: rtl/cordic_rot_ctrl.sv
module cordic_rot_ctrl
  import cordic_rot_pkg::*;
#(
  parameter int ANGLE_W    = 10,
  parameter int STAGES     = 16,
  parameter int ANGLE_FRAC = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [ANGLE_W-1:0]  inAngle,
  output coarseStrobe_t       coarse,
  output logic [STAGES-1:0]   dirUp,
  output logic [STAGES:0]     stageValid,
  output logic                outValid
);

  localparam int ZW    = ANGLE_FRAC + 3;
  localparam int LOW_W = ANGLE_W - 2;
  localparam logic signed [ZW-1:0] STEP_FX    = ZW'(stepFixed(ANGLE_W, ANGLE_FRAC));
  localparam logic signed [ZW-1:0] QUARTER    = ZW'(2 ** LOW_W);
  localparam logic signed [ZW-1:0] QPI_BOUND  = ZW'(quarterPiFixed(ANGLE_FRAC) + (2 ** ANGLE_W));
  localparam logic signed [ZW-1:0] CONV_BOUND = ZW'(atanFixed(STAGES, ANGLE_FRAC) + STAGES + 2);

  logic [1:0]             topBits;
  logic                   halfBit;
  logic signed [ZW-1:0]   lowExt;
  logic signed [ZW-1:0]   rrIdx;
  logic signed [ZW-1:0]   phiFx;
  logic signed [ZW-1:0]   zAll [0:STAGES];
  logic signed [ZW-1:0]   zFirst;
  logic [STAGES+1:0]      vPipe;

  // Quarter-turn choice and residual index in [-N/8, N/8)
  always_comb begin
    topBits     = inAngle[ANGLE_W-1 -: 2];
    halfBit     = inAngle[LOW_W-1];
    lowExt      = ZW'(inAngle[LOW_W-1:0]);
    rrIdx       = halfBit ? (lowExt - QUARTER) : lowExt;
    phiFx       = -(rrIdx * STEP_FX);
    coarse.quad = quadSel_e'(topBits + {1'b0, halfBit});
    coarse.take = inValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        zFirst <= '0;
    else if (inValid) zFirst <= phiFx;
  end
  assign zAll[0] = zFirst;

  genvar k;
  generate
    for (k = 0; k < STAGES; k++) begin : g_dir
      assign dirUp[k] = ~zAll[k][ZW-1];
    end
    for (k = 1; k <= STAGES; k++) begin : g_resid
      localparam logic signed [ZW-1:0] ATAN_K = ZW'(atanFixed(k, ANGLE_FRAC));
      logic signed [ZW-1:0] zReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 zReg <= '0;
        else if (stageValid[k-1])  zReg <= dirUp[k-1] ? (zAll[k-1] - ATAN_K)
                                                     : (zAll[k-1] + ATAN_K);
      end
      assign zAll[k] = zReg;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vPipe <= '0;
    else       vPipe <= {vPipe[STAGES:0], inValid};
  end
  assign stageValid = vPipe[STAGES:0];
  assign outValid   = vPipe[STAGES+1];

  logic signed [ZW-1:0] zAbs0, zAbsLast;
  always_comb begin
    zAbs0    = (zAll[0] < 0) ? -zAll[0] : zAll[0];
    zAbsLast = (zAll[STAGES] < 0) ? -zAll[STAGES] : zAll[STAGES];
  end

  // R3
  residual_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    stageValid[0] |-> (zAbs0 <= QPI_BOUND));

  // R1
  residual_conv_chk: assert property (@(posedge clk) disable iff (!rstN)
    stageValid[STAGES] |-> (zAbsLast <= CONV_BOUND));

endmodule

// File: rtl/cordic_rot_dp.sv
module cordic_rot_dp
  import cordic_rot_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int STAGES = 16,
  parameter int GUARD  = 4,
  parameter int GAIN_W = 18
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  coarseStrobe_t            coarse,
  input  logic signed [DATA_W-1:0] inX,
  input  logic signed [DATA_W-1:0] inY,
  input  logic [STAGES-1:0]        dirUp,
  input  logic [STAGES:0]          stageValid,
  output logic signed [DATA_W-1:0] outX,
  output logic signed [DATA_W-1:0] outY
);

  localparam int IW  = DATA_W + 2 + GUARD;
  localparam int PRW = IW + GAIN_W + 1;
  localparam int SH  = GAIN_W + GUARD;
  localparam logic signed [GAIN_W:0]   GAIN_FX = (GAIN_W + 1)'(gainFixed(STAGES, GAIN_W));
  localparam logic signed [PRW-1:0]    HALF    = {{(PRW-SH){1'b0}}, 1'b1, {(SH-1){1'b0}}};
  localparam logic signed [DATA_W-1:0] OUT_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] OUT_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [IW-1:0] xe, ye, cx, cy;
  logic signed [IW-1:0] xAll [0:STAGES];
  logic signed [IW-1:0] yAll [0:STAGES];
  logic signed [IW-1:0] xFirst, yFirst;

  // Exact quarter turns: swap and negate only
  always_comb begin
    xe = {{2{inX[DATA_W-1]}}, inX, {GUARD{1'b0}}};
    ye = {{2{inY[DATA_W-1]}}, inY, {GUARD{1'b0}}};
    case (coarse.quad)
      QUAD_NONE:  begin cx = xe;  cy = ye;  end
      QUAD_CW90:  begin cx = ye;  cy = -xe; end
      QUAD_CW180: begin cx = -xe; cy = -ye; end
      default:    begin cx = -ye; cy = xe;  end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xFirst <= '0;
      yFirst <= '0;
    end else if (coarse.take) begin
      xFirst <= cx;
      yFirst <= cy;
    end
  end
  assign xAll[0] = xFirst;
  assign yAll[0] = yFirst;

  genvar k;
  generate
    for (k = 1; k <= STAGES; k++) begin : g_micro
      logic signed [IW-1:0] xReg, yReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          xReg <= '0;
          yReg <= '0;
        end else if (stageValid[k-1]) begin
          if (dirUp[k-1]) begin
            xReg <= xAll[k-1] - (yAll[k-1] >>> k);
            yReg <= yAll[k-1] + (xAll[k-1] >>> k);
          end else begin
            xReg <= xAll[k-1] + (yAll[k-1] >>> k);
            yReg <= yAll[k-1] - (xAll[k-1] >>> k);
          end
        end
      end
      assign xAll[k] = xReg;
      assign yAll[k] = yReg;
    end
  endgenerate

  function automatic logic signed [DATA_W-1:0] satRound(input logic signed [PRW-1:0] p);
    logic signed [PRW-1:0] s;
    s = (p + HALF) >>> SH;
    if (s > PRW'(OUT_MAX))      return OUT_MAX;
    else if (s < PRW'(OUT_MIN)) return OUT_MIN;
    else                        return s[DATA_W-1:0];
  endfunction

  logic signed [PRW-1:0] prodX, prodY;
  always_comb begin
    prodX = PRW'(xAll[STAGES]) * PRW'(GAIN_FX);
    prodY = PRW'(yAll[STAGES]) * PRW'(GAIN_FX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outX <= '0;
      outY <= '0;
    end else if (stageValid[STAGES]) begin
      outX <= satRound(prodX);
      outY <= satRound(prodY);
    end
  end

  function automatic logic [IW:0] magSum(input logic signed [IW-1:0] a,
                                         input logic signed [IW-1:0] b);
    logic [IW-1:0] aa, bb;
    aa = a[IW-1] ? IW'(-a) : IW'(a);
    bb = b[IW-1] ? IW'(-b) : IW'(b);
    return {1'b0, aa} + {1'b0, bb};
  endfunction

  logic [IW:0] inMag, coarseMag;
  always_comb begin
    inMag     = magSum(xe, ye);
    coarseMag = magSum(xAll[0], yAll[0]);
  end

  // R2
  coarse_mag_chk: assert property (@(posedge clk) disable iff (!rstN)
    coarse.take |=> (coarseMag == $past(inMag)));

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stageValid[STAGES] |=> ($stable(outX) && $stable(outY)));

endmodule

// File: rtl/cordic_rotator.sv
module cordic_rotator
  import cordic_rot_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ANGLE_W    = 10,
  parameter int STAGES     = 16,
  parameter int ANGLE_FRAC = 24,
  parameter int GUARD      = 4,
  parameter int GAIN_W     = 18
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [ANGLE_W-1:0]       inAngle,
  input  logic signed [DATA_W-1:0] inX,
  input  logic signed [DATA_W-1:0] inY,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outX,
  output logic signed [DATA_W-1:0] outY
);

  coarseStrobe_t       coarseBus;
  logic [STAGES-1:0]   dirUp;
  logic [STAGES:0]     stageValid;

  cordic_rot_ctrl #(
    .ANGLE_W(ANGLE_W), .STAGES(STAGES), .ANGLE_FRAC(ANGLE_FRAC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inAngle(inAngle),
    .coarse(coarseBus), .dirUp(dirUp), .stageValid(stageValid),
    .outValid(outValid)
  );

  cordic_rot_dp #(
    .DATA_W(DATA_W), .STAGES(STAGES), .GUARD(GUARD), .GAIN_W(GAIN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .coarse(coarseBus), .inX(inX), .inY(inY),
    .dirUp(dirUp), .stageValid(stageValid), .outX(outX), .outY(outY)
  );

endmodule

// File: tb/cordic_rotator_test.sv
module cordic_rotator_test;

  localparam int DATA_W  = 16;
  localparam int ANGLE_W = 10;
  localparam int STAGES  = 16;
  localparam int N       = 1 << ANGLE_W;
  localparam int TOL     = 4;
  localparam int LAT     = STAGES + 2;   // negedge-to-negedge distance
  localparam int OMAX    = (1 << (DATA_W - 1)) - 1;
  localparam int OMIN    = -(1 << (DATA_W - 1));
  localparam real PI     = 3.141592653589793;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [ANGLE_W-1:0] inAngle = '0;
  logic signed [DATA_W-1:0] inX = '0;
  logic signed [DATA_W-1:0] inY = '0;
  logic outValid;
  logic signed [DATA_W-1:0] outX, outY;

  cordic_rotator #(.DATA_W(DATA_W), .ANGLE_W(ANGLE_W), .STAGES(STAGES)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inAngle(inAngle),
    .inX(inX), .inY(inY), .outValid(outValid), .outX(outX), .outY(outY)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int ex; int ey; int due; int req; } expItem_t;
  expItem_t sb[$];

  int total = 0;
  int bad = 0;
  bit monOn = 0;
  bit done = 0;
  int lastX = 0;
  int lastY = 0;
  bit [31:0] rs = 32'h2545F491;

  function automatic bit [31:0] nextRand();
    rs ^= rs << 13;
    rs ^= rs >> 17;
    rs ^= rs << 5;
    return rs;
  endfunction

  function automatic int rnd(input real v);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  function automatic int clampOut(input int v);
    if (v > OMAX) return OMAX;
    if (v < OMIN) return OMIN;
    return v;
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic check(input bit ok, input int req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: offers one sample and queues its expected result
  task automatic send(input int x, input int y, input int th, input int req);
    real phi, c, s;
    int ex, ey;
    phi = 2.0 * PI * th / N;
    c = $cos(phi);
    s = $sin(phi);
    ex = clampOut(rnd(x * c + y * s));
    ey = clampOut(rnd(-x * s + y * c));
    @(negedge clk);
    inValid = 1'b1;
    inX = x[DATA_W-1:0];
    inY = y[DATA_W-1:0];
    inAngle = th[ANGLE_W-1:0];
    sb.push_back('{ex, ey, cyc + LAT, req});
  endtask

  // Idle cycles with garbage on the data inputs (R6)
  task automatic pause(input int n);
    for (int i = 0; i < n; i++) begin
      bit [31:0] r;
      @(negedge clk);
      r = nextRand();
      inValid = 1'b0;
      inX = r[DATA_W-1:0];
      inY = r[31 -: DATA_W];
      inAngle = r[ANGLE_W+3:4];
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (monOn) begin
      if (outValid) begin
        if (sb.size() == 0) begin
          check(1'b0, 5, "output with nothing pending", 1, 0);
        end else begin
          expItem_t it;
          it = sb.pop_front();
          check(cyc == it.due, 4, "latency cycle", cyc, it.due);
          check(iabs(int'(outX) - it.ex) <= TOL, it.req, "outX", int'(outX), it.ex);
          check(iabs(int'(outY) - it.ey) <= TOL, it.req, "outY", int'(outY), it.ey);
        end
        lastX = int'(outX);
        lastY = int'(outY);
      end else begin
        check(int'(outX) == lastX, 6, "outX hold", int'(outX), lastX);
        check(int'(outY) == lastY, 6, "outY hold", int'(outY), lastY);
        if (sb.size() > 0 && sb[0].due <= cyc) begin
          expItem_t gone;
          gone = sb.pop_front();
          check(1'b0, 4, "missing output", 0, gone.due);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: during reset
    check(outValid == 1'b0, 9, "outValid in reset", int'(outValid), 0);
    check(outX == '0 && outY == '0, 9, "outputs in reset", int'(outX), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R9: after release
    check(outValid == 1'b0, 9, "outValid after reset", int'(outValid), 0);
    check(outX == '0, 9, "outX after reset", int'(outX), 0);
    check(outY == '0, 9, "outY after reset", int'(outY), 0);
    monOn = 1;

    // R8: gain compensation, no net angle
    send(20000, 0, 0, 8);
    send(0, -15000, 0, 8);
    pause(2);

    // R2: exact quarter turns
    send(12000, -7000, N / 4, 2);
    send(12000, -7000, N / 2, 2);
    send(12000, -7000, 3 * N / 4, 2);
    send(-9000, 30000, N / 4, 2);
    pause(3);

    // R3: residual at the +/-45 degree edges
    for (int q = 1; q < 8; q += 2) begin
      send(25000, 10000, q * N / 8 - 1, 3);
      send(25000, 10000, q * N / 8, 3);
    end
    send(-20000, 17000, N - 1, 3);
    pause(2);

    // R7: saturation
    send(32767, 32767, 7 * N / 8, 7);
    send(-32768, -32768, N / 8, 7);
    send(-32768, 0, N / 2, 7);
    send(0, -32768, N / 2, 7);
    pause(4);

    // R5: back-to-back stream, all angles random (R1)
    for (int i = 0; i < 150; i++) begin
      bit [31:0] r;
      r = nextRand();
      send(int'($signed(r[DATA_W-1:0])) / 2, int'($signed(r[31 -: DATA_W])) / 2,
           int'(r[ANGLE_W+7:8]), 5);
    end

    // R1 / R6: sparse traffic with garbage in the gaps
    for (int i = 0; i < 60; i++) begin
      bit [31:0] r;
      r = nextRand();
      send(int'($signed(r[DATA_W-1:0])), int'($signed(r[31 -: DATA_W])),
           int'(r[ANGLE_W+5:6]), 1);
      pause(1 + int'(r[3:2]));
    end

    pause(LAT + 6);
    check(sb.size() == 0, 4, "results still pending", sb.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R4 watchdog expired: actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule